// File: doc/BRIEF.md
# Clock-Compensation Rate Match FIFO

This block is an elastic buffer between a recovered receive clock and a local read clock. It carries 9-bit symbols: bit 8 marks a control character and bits 7:0 hold the byte. The two clocks run at nominally equal but not identical rates. The buffer absorbs the difference by editing skip clusters. A skip cluster is a run of back-to-back skip symbols, whose value is set by a parameter. The write side drops skips when the buffer runs high. The read side repeats a skip when the buffer runs low.

When the margins are used up, the block protects itself. If a symbol arrives while the buffer is full, that symbol is discarded. The next symbol presented carries a full pulse. If the reader finds nothing to read, it emits a filler control symbol and flags the first filler of that gap. The write and read pointers cross between the clock domains as Gray codes, each through a two-stage synchronizer.

The stream rules are strict because neither side can apply back-pressure. The writer presents a symbol with `wr_valid` whenever it has one, and the block never stalls it. The reader takes exactly one symbol on every `rd_clk` cycle out of reset. Each side has its own synchronous, active-high reset.

Top module: `clk_comp_fifo`

## Requirements
- R1: On the write side, a skip symbol (`SKIP_SYM`, default 9'h1BC) is discarded when all three of these hold: the seen fill level is above `HI_TH` (default 12), an earlier skip of the same cluster was stored, and fewer than `MAX_DEL` (4) skips of this cluster were already discarded. The first skip of a cluster is never removed this way.
- R2: On the read side, a skip at the read head is output again without advancing when all three of these hold: the fill level is below `LO_TH` (default 4), fewer than `MAX_INS` (4) repeats were made in this cluster, and the number of skips already output in this cluster plus two is below `CLUSTER_LIM` (5). With the defaults, a lone skip leaves the block four times. Only a real non-skip symbol ends a read-side cluster; fillers do not end it.
- R3: A symbol that arrives while `2**AW` (16) symbols are stored, and that R1 does not discard, is dropped. The buffer never holds more than 16 symbols.
- R4: `full_flag` is high, combinationally with `wr_valid`, during the next valid write that follows a dropped symbol. It is low during every other write.
- R5: When no stored symbol is available, `rd_sym` carries the filler 9'h1FE (control bit set, byte 0xFE) and the read pointer does not move.
- R6: `empty_flag` is a one-cycle pulse, aligned with the first filler after a real symbol. Later fillers of the same gap are not flagged, and neither are fillers that follow a read-side reset.
- R7: Every symbol that is neither discarded nor dropped appears on `rd_sym` in write order. The output takes one register stage after the read head. A data symbol is never repeated.
- R8: While either reset is high, that domain's pointer and flag are cleared. The read side outputs the filler with `empty_flag` low.
- R9: A skip that meets R1 while the buffer is full is discarded, not dropped, and raises no `full_flag` on the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | A symbol is presented on `wr_sym` this cycle |
| wr_sym | input | 9 | Incoming symbol: bit 8 control flag, bits 7:0 byte |
| full_flag | output | 1 | Pulse on the write following a dropped symbol |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_sym | output | 9 | Outgoing symbol, one per read cycle |
| empty_flag | output | 1 | Pulse aligned with the first filler of an underrun |

## Verification
On the write side, skip deletion and overflow drop can both apply to the same symbol: a skip that arrives at full fill inside a cluster that already stored one skip. The bench holds the read domain in reset, so the write side sees a read pointer of zero and the fill level follows from the writes alone. It then sends fifteen data symbols and a six-skip cluster. It expects skips two to five to be discarded with no full pulse, the sixth to be dropped, and the next data symbol to carry `full_flag`. The read side is then released and the drained stream is compared: the single stored skip must be stretched by repeats at low fill.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int SYM_W = 9;
  typedef logic [SYM_W-1:0] sym_t;
  localparam sym_t FILLER_SYM = 9'h1FE;
endpackage

// File: rtl/ccf_sync.sv
module ccf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the XOR of all higher gray bits and itself.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ stage2[i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/ccf_wr_ctl.sv
module ccf_wr_ctl
  import ccf_pkg::*;
#(
  parameter int   AW       = 4,
  parameter int   HI_TH    = 12,
  parameter int   MAX_DEL  = 4,
  parameter sym_t SKIP_SYM = 9'h1BC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  sym_t          in_sym,
  input  logic [AW:0]   rd_bin,
  output logic [AW:0]   wr_bin,
  output logic [AW:0]   wr_gray,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          full_flag
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(MAX_DEL + 1);

  logic [PW-1:0] fill;
  logic          is_skip, at_full, del_now, drop_now;
  logic          kept_any, drop_pend;
  logic [CW-1:0] del_cnt;

  assign fill     = wr_bin - rd_bin;
  assign at_full  = (fill == PW'(DEPTH));
  assign is_skip  = in_valid && (in_sym == SKIP_SYM);
  // Deletion outranks the overflow drop.
  assign del_now  = is_skip && kept_any && (del_cnt < CW'(MAX_DEL)) && (fill > PW'(HI_TH));
  assign drop_now = in_valid && !del_now && at_full;
  assign we       = in_valid && !del_now && !at_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin    <= '0;
      kept_any  <= 1'b0;
      del_cnt   <= '0;
      drop_pend <= 1'b0;
    end else begin
      if (we) wr_bin <= wr_bin + 1'b1;
      if (in_valid) begin
        drop_pend <= drop_now;
        if (!is_skip) begin
          kept_any <= 1'b0;
          del_cnt  <= '0;
        end else begin
          if (we)      kept_any <= 1'b1;
          if (del_now) del_cnt  <= del_cnt + 1'b1;
        end
      end
    end
  end

  assign full_flag = in_valid && drop_pend;
  assign wr_gray   = wr_bin ^ (wr_bin >> 1);
  assign waddr     = wr_bin[AW-1:0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= PW'(DEPTH)); // R3
  AST_DEL_CAP: assert property (@(posedge clk) disable iff (rst)
    del_cnt <= CW'(MAX_DEL)); // R1
  AST_FULL_PULSE: assert property (@(posedge clk) disable iff (rst)
    (full_flag && !drop_now) |=> !full_flag); // R4
endmodule

// File: rtl/ccf_rd_ctl.sv
module ccf_rd_ctl
  import ccf_pkg::*;
#(
  parameter int   AW          = 4,
  parameter int   LO_TH       = 4,
  parameter int   MAX_INS     = 4,
  parameter int   CLUSTER_LIM = 5,
  parameter sym_t SKIP_SYM    = 9'h1BC
) (
  input  logic          clk,
  input  logic          rst,
  input  sym_t          head_sym,
  input  logic [AW:0]   wr_bin,
  output logic [AW:0]   rd_bin,
  output logic [AW:0]   rd_gray,
  output logic [AW-1:0] raddr,
  output sym_t          out_sym,
  output logic          empty_flag
);
  localparam int PW = AW + 1;
  localparam int RW = $clog2(CLUSTER_LIM + 1);
  localparam int IW = $clog2(MAX_INS + 1);

  logic [PW-1:0] fill;
  logic          is_empty, head_skip, rep_now, adv;
  logic          was_empty;
  logic [RW-1:0] run;
  logic [IW-1:0] ins_cnt;

  assign fill      = wr_bin - rd_bin;
  assign is_empty  = (fill == '0);
  assign head_skip = (head_sym == SKIP_SYM);
  assign rep_now   = !is_empty && head_skip && (fill < PW'(LO_TH)) &&
                     (ins_cnt < IW'(MAX_INS)) && (int'(run) + 2 < CLUSTER_LIM);
  assign adv       = !is_empty && !rep_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin     <= '0;
      out_sym    <= FILLER_SYM;
      empty_flag <= 1'b0;
      was_empty  <= 1'b1;
      run        <= '0;
      ins_cnt    <= '0;
    end else begin
      empty_flag <= is_empty && !was_empty;
      was_empty  <= is_empty;
      if (is_empty) begin
        out_sym <= FILLER_SYM;
      end else begin
        out_sym <= head_sym;
        if (head_skip) begin
          if (int'(run) < CLUSTER_LIM) run <= run + 1'b1;
          if (rep_now) ins_cnt <= ins_cnt + 1'b1;
        end else begin
          run     <= '0;
          ins_cnt <= '0;
        end
      end
      if (adv) rd_bin <= rd_bin + 1'b1;
    end
  end

  assign rd_gray = rd_bin ^ (rd_bin >> 1);
  assign raddr   = rd_bin[AW-1:0];

  AST_INS_CAP: assert property (@(posedge clk) disable iff (rst)
    ins_cnt <= IW'(MAX_INS)); // R2
  AST_FILLER_TAG: assert property (@(posedge clk) disable iff (rst)
    empty_flag |-> (out_sym == FILLER_SYM)); // R5
  AST_EMPTY_PULSE: assert property (@(posedge clk) disable iff (rst)
    empty_flag |=> !empty_flag); // R6
  AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    is_empty |=> $stable(rd_bin)); // R5
endmodule

// File: rtl/clk_comp_fifo.sv
module clk_comp_fifo
  import ccf_pkg::*;
#(
  parameter int   AW          = 4,
  parameter int   HI_TH       = 12,
  parameter int   LO_TH       = 4,
  parameter int   MAX_DEL     = 4,
  parameter int   MAX_INS     = 4,
  parameter int   CLUSTER_LIM = 5,
  parameter sym_t SKIP_SYM    = 9'h1BC
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic       wr_valid,
  input  logic [8:0] wr_sym,
  output logic       full_flag,
  input  logic       rd_clk,
  input  logic       rd_rst,
  output logic [8:0] rd_sym,
  output logic       empty_flag
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  sym_t          mem [DEPTH];
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] wr_bin_in_rd, rd_bin_in_wr;
  sym_t          head_sym;

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wr_sym;
  end
  assign head_sym = mem[raddr];

  ccf_wr_ctl #(.AW(AW), .HI_TH(HI_TH), .MAX_DEL(MAX_DEL), .SKIP_SYM(SKIP_SYM)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid), .in_sym(wr_sym),
    .rd_bin(rd_bin_in_wr), .wr_bin(wr_bin), .wr_gray(wr_gray), .we(we),
    .waddr(waddr), .full_flag(full_flag)
  );

  ccf_rd_ctl #(.AW(AW), .LO_TH(LO_TH), .MAX_INS(MAX_INS), .CLUSTER_LIM(CLUSTER_LIM),
               .SKIP_SYM(SKIP_SYM)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .head_sym(head_sym), .wr_bin(wr_bin_in_rd),
    .rd_bin(rd_bin), .rd_gray(rd_gray), .raddr(raddr), .out_sym(rd_sym),
    .empty_flag(empty_flag)
  );

  ccf_sync #(.W(PW)) u_wptr_sync (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wr_bin_in_rd)
  );

  ccf_sync #(.W(PW)) u_rptr_sync (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rd_gray), .bin_out(rd_bin_in_wr)
  );
endmodule

// File: tb/clk_comp_fifo_test.sv
module clk_comp_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam logic [8:0] SKIP = 9'h1BC;
  localparam logic [8:0] FILL = 9'h1FE;
  localparam int NV = 10;
  // {expected appearances on the output, stimulus symbol}
  localparam logic [12:0] VECS [NV] = '{
    {4'd1, 9'h011}, {4'd1, 9'h022}, {4'd4, SKIP}, {4'd1, 9'h033}, {4'd4, SKIP},
    {4'd1, SKIP},   {4'd1, 9'h0A5}, {4'd1, 9'h17C}, {4'd4, SKIP}, {4'd1, 9'h000}
  };

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b1, rd_rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_sym = '0;
  logic       full_flag, empty_flag;
  logic [8:0] rd_sym;

  int n_chk = 0, n_bad = 0;
  logic [8:0] cap [256];
  int  cap_n = 0, empty_pulses = 0, empty_bad = 0;
  bit  cap_en = 1'b0, cap_clr = 1'b0, prev_e = 1'b0;

  always #(CLK_PERIOD / 2) wr_clk = ~wr_clk;
  always #(RD_PERIOD / 2)  rd_clk = ~rd_clk;

  clk_comp_fifo uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_sym(wr_sym),
    .full_flag(full_flag), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_sym(rd_sym),
    .empty_flag(empty_flag)
  );

  always @(negedge rd_clk) begin
    if (cap_clr) begin
      cap_n = 0; empty_pulses = 0; empty_bad = 0; prev_e = 1'b0;
    end else if (cap_en && !rd_rst) begin
      if (rd_sym != FILL && cap_n < 256) begin
        cap[cap_n] = rd_sym;
        cap_n++;
      end
      if (empty_flag) begin
        empty_pulses++;
        if (rd_sym != FILL) empty_bad++;
        if (prev_e) empty_bad++;
      end
      prev_e = empty_flag;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [8:0] s, input int exp_full, input string req);
    @(negedge wr_clk);
    wr_sym   = s;
    wr_valid = 1'b1;
    #1;
    check(req, int'(full_flag), exp_full);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_valid = 1'b0;
    end
  endtask

  task automatic clear_capture();
    cap_clr = 1'b1;
    @(posedge rd_clk);
    @(posedge rd_clk);
    cap_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int e;
    // Reset state, R8
    repeat (4) @(negedge rd_clk);
    check("R8 rd_sym in reset", int'(rd_sym), int'(FILL));
    check("R8 empty_flag in reset", int'(empty_flag), 0);
    check("R8 full_flag in reset", int'(full_flag), 0);
    @(negedge wr_clk); wr_rst = 1'b0;
    @(negedge rd_clk); rd_rst = 1'b0;

    // Fillers straight after reset carry no flag, R6
    clear_capture();
    cap_en = 1'b1;
    repeat (6) @(negedge rd_clk);
    check("R6 no flag after reset", empty_pulses, 0);

    // Table walk: slow writer, fast reader, low fill
    clear_capture();
    for (int i = 0; i < NV; i++) begin
      put(VECS[i][8:0], 0, "R4 no full pulse at low fill");
      idle(2);
    end
    idle(40);
    e = 0;
    for (int i = 0; i < NV; i++) e += int'(VECS[i][12:9]);
    check("R7 output count table", cap_n, e);
    e = 0;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VECS[i][12:9]); k++) begin
        if (e < cap_n)
          check(VECS[i][8:0] == SKIP ? "R2 skip repeat" : "R7 order", int'(cap[e]), int'(VECS[i][8:0]));
        e++;
      end
    end
    check("R6 underflow flagged", int'(empty_pulses > 0), 1);
    check("R5 flag only with filler, single cycle", empty_bad, 0);

    // Deletion meets overflow: read side held in reset
    cap_en = 1'b0;
    @(negedge wr_clk); wr_rst = 1'b1;
    @(negedge rd_clk); rd_rst = 1'b1;
    repeat (3) @(negedge wr_clk);
    wr_rst = 1'b0;
    repeat (3) @(negedge wr_clk);
    for (int i = 0; i < 15; i++) put(9'h040 + 9'(i), 0, "R3 filling");
    put(SKIP, 0, "R1 first skip kept");
    for (int i = 0; i < 4; i++) put(SKIP, 0, "R9 deleted skip at full raises no flag");
    put(SKIP, 0, "R1 fifth removal refused");
    put(9'h050, 1, "R4 full pulse after dropped skip");
    put(9'h051, 1, "R3 data dropped at full");
    idle(1);
    put(9'h052, 1, "R4 pulse on next valid write");
    idle(4);

    clear_capture();
    cap_en = 1'b1;
    @(negedge rd_clk); rd_rst = 1'b0;
    repeat (40) @(negedge rd_clk);
    check("R3 stored count", cap_n, 19);
    for (int i = 0; i < 15; i++)
      if (i < cap_n) check("R7 drained order", int'(cap[i]), int'(9'h040 + 9'(i)));
    for (int i = 15; i < 19; i++)
      if (i < cap_n) check("R2 stretched skip", int'(cap[i]), int'(SKIP));
    check("R6 single flag after drain", empty_pulses, 1);
    check("R5 filler with flag", empty_bad, 0);
    check("R5 idle output filler", int'(rd_sym), int'(FILL));

    summary();
    $finish;
  end
endmodule